// File: doc/BRIEF.md
# Zone Erase Sequencer

This block drives the command bus of a flash array to erase one zone of it. A run is started by a pulse on `start_i`, which captures the zone base address and the number of locations in the zone. The sequencer first brings every location of the zone to the all-zero state. It does this by handing each address, in ascending order, to an external program-and-verify controller over a request/done handshake. Only when all locations have been programmed does it begin erasing.

Erasure is a closed loop. Each erase pulse is a setup write and an erase write, both carrying the erase command byte, followed by a timed wait. A verify-command write at the current verify address and a settle wait come next, and then one read of that location. Verification walks upward from the zone base. A location that does not read as fully erased stops the walk and triggers another pulse, after which the walk resumes at that same location rather than at the base. The data bus is made of byte lanes. In the default two-lane build, a lane that has already verified at the current location receives the no-operation byte instead of real commands, so that it sees no further erase stress. That masking is dropped when the walk moves to a new location.

The number of erase pulses per run is bounded by a parameter. A run ends with a read-mode write, after which `done_o` is raised and `err_o` reports whether the zone was left unfinished, either because the pulse budget ran out or because the program controller reported a failure.

Top module: `zone_erase_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `prg_req_o`, `bus_we_o` and `bus_re_o` are all low.
- R2: A start accepted while idle raises `busy_o`. It programs each location from `base_i` to `base_i+size_i-1` in ascending order, one at a time, using `prg_req_o`/`prg_addr_o`/`prg_done_i` (`size_i` >= 1). No bus write and no bus read occur while `prg_req_o` is high, and no erase pulse occurs before the last location is programmed.
- R3: If `prg_done_i` arrives with `prg_fail_i` high, no erase pulse is issued. The run ends as in R9 with `err_o` high.
- R4: An erase pulse on a lane is two writes on consecutive cycles whose byte on that lane (lane l = `bus_wdata_o[8l+7:8l]`) is 20H. The verify command (byte A0H) is written ERASE_CYC+1 cycles after the second 20H write. The single read of the location (`bus_re_o`) comes SETTLE_CYC+1 cycles after the verify write. Write and read are never high together.
- R5: The first verify follows the first pulse at the zone base. A location passes when every lane reads FFH. A passing location that is not the last is followed directly by a verify of the next location, with no new pulse.
- R6: A failing location is re-verified after the next pulse, so verify addresses never decrease within a run. A run without error issues exactly `size_i` + (pulses - 1) verify writes.
- R7: A lane that reads FFH at a failing location gets byte FFH in place of 20H and A0H until the walk advances. On advancing, all lanes get full commands again.
- R8: At most MAX_PULSES erase pulses are issued per run. A failing verify after the MAX_PULSES-th pulse ends the run as in R9 with `err_o` high.
- R9: Every run ends with one write of all-zero data. `busy_o` then drops, `done_o` rises, and both `done_o` and `err_o` hold until the next accepted start. A run that erases the whole zone ends with `err_o` low.
- R10: `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a zone erase (sampled while idle) |
| base_i | input | AW | First address of the zone |
| size_i | input | AW | Number of locations in the zone, at least 1 |
| prg_req_o | output | 1 | Request to program `prg_addr_o` to zero |
| prg_addr_o | output | AW | Address handed to the program controller |
| prg_done_i | input | 1 | Program controller finished the current address |
| prg_fail_i | input | 1 | Qualifies `prg_done_i`: programming failed |
| bus_we_o | output | 1 | Command write strobe |
| bus_re_o | output | 1 | Read strobe, data sampled in the same cycle |
| bus_addr_o | output | AW | Command/read address |
| bus_wdata_o | output | 8*LANES | Command data, one byte per lane |
| bus_rdata_i | input | 8*LANES | Read data from the array |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run has ended |
| err_o | output | 1 | Last run ended without a fully erased zone |

## Verification
The checker watches, on every cycle, the properties that need no knowledge of the array contents. These are: write and read strobes never overlap, the bus stays quiet during pre-programming, verify addresses never step back, the pulse count stays within budget, and `done_o` never coexists with `busy_o` and holds while idle. Only the bench's array model can show that the walk resumes at the failing location rather than at the base, that each lane receives the number of pulses its own cells need under masking, and that wait lengths and the final read-mode write are right. The bench sweeps zone sizes and need patterns, and also covers budget exhaustion, programming failure and a start pulse during a run.

// File: rtl/zes_pkg.sv
package zes_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRG, ST_ESETUP, ST_ERASE, ST_EWAIT,
    ST_VCMD, ST_VWAIT, ST_VREAD, ST_RDRST
  } zes_state_e;

  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_VFY   = 8'hA0;
  localparam logic [7:0] CMD_NOP   = 8'hFF;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;
endpackage

// File: rtl/zes_delay.sv
module zes_delay #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/zes_lane.sv
module zes_lane
  import zes_pkg::*;
(
  input  logic [7:0] rdata_i,
  input  logic       mask_i,
  input  logic [7:0] cmd_i,
  output logic       pass_o,
  output logic [7:0] cmd_o
);
  // a masked lane already verified here; it keeps passing and gets no-ops
  assign pass_o = mask_i | (rdata_i == BYTE_ERASED);
  assign cmd_o  = mask_i ? CMD_NOP : cmd_i;
endmodule

// File: rtl/zone_erase_seq.sv
module zone_erase_seq
  import zes_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned LANES      = 2,
  parameter int unsigned ERASE_CYC  = 16,
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned MAX_PULSES = 25,
  localparam int unsigned DW        = 8 * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic          prg_req_o,
  output logic [AW-1:0] prg_addr_o,
  input  logic          prg_done_i,
  input  logic          prg_fail_i,
  output logic          bus_we_o,
  output logic          bus_re_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int unsigned TMAX = (ERASE_CYC > SETTLE_CYC) ? ERASE_CYC : SETTLE_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned FCW  = $clog2(MAX_PULSES + 1);

  zes_state_e state_q;
  logic [AW-1:0]    base_q, last_q, ptr_q;
  logic [LANES-1:0] mask_q, pass;
  logic [FCW-1:0]   fcnt_q;
  logic             done_q, err_q;
  logic [7:0]       cmd_byte;
  logic [LANES-1:0][7:0] lane_cmd;
  logic             tmr_load, tmr_zero;
  logic [TW-1:0]    tmr_val;

  always_comb begin
    unique case (state_q)
      ST_ESETUP, ST_ERASE: cmd_byte = CMD_ERASE;
      ST_VCMD:             cmd_byte = CMD_VFY;
      default:             cmd_byte = CMD_NOP;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    zes_lane u_lane (
      .rdata_i (bus_rdata_i[8*g +: 8]),
      .mask_i  (mask_q[g]),
      .cmd_i   (cmd_byte),
      .pass_o  (pass[g]),
      .cmd_o   (lane_cmd[g])
    );
  end

  assign tmr_load = (state_q == ST_ERASE) || (state_q == ST_VCMD);
  assign tmr_val  = (state_q == ST_ERASE) ? TW'(ERASE_CYC - 1) : TW'(SETTLE_CYC - 1);

  zes_delay #(.W(TW)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      last_q  <= '0;
      ptr_q   <= '0;
      mask_q  <= '0;
      fcnt_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q  <= base_i;
          last_q  <= size_i - AW'(1);
          ptr_q   <= '0;
          mask_q  <= '0;
          fcnt_q  <= '0;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
          state_q <= ST_PRG;
        end
        ST_PRG: if (prg_done_i) begin
          if (prg_fail_i) begin
            err_q   <= 1'b1;
            state_q <= ST_RDRST;
          end else if (ptr_q == last_q) begin
            ptr_q   <= '0;
            state_q <= ST_ESETUP;
          end else begin
            ptr_q <= ptr_q + AW'(1);
          end
        end
        ST_ESETUP: state_q <= ST_ERASE;
        ST_ERASE:  state_q <= ST_EWAIT;
        ST_EWAIT:  if (tmr_zero) state_q <= ST_VCMD;
        ST_VCMD:   state_q <= ST_VWAIT;
        ST_VWAIT:  if (tmr_zero) state_q <= ST_VREAD;
        ST_VREAD: begin
          if (&pass) begin
            mask_q <= '0;
            if (ptr_q == last_q) begin
              state_q <= ST_RDRST;
            end else begin
              ptr_q   <= ptr_q + AW'(1);
              state_q <= ST_VCMD;
            end
          end else begin
            mask_q <= pass;
            if (fcnt_q == FCW'(MAX_PULSES - 1)) begin
              err_q   <= 1'b1;
              state_q <= ST_RDRST;
            end else begin
              fcnt_q  <= fcnt_q + FCW'(1);
              state_q <= ST_ESETUP;
            end
          end
        end
        ST_RDRST: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign prg_req_o   = (state_q == ST_PRG);
  assign prg_addr_o  = base_q + ptr_q;
  assign bus_addr_o  = base_q + ptr_q;
  assign bus_we_o    = (state_q == ST_ESETUP) || (state_q == ST_ERASE) ||
                       (state_q == ST_VCMD)   || (state_q == ST_RDRST);
  assign bus_re_o    = (state_q == ST_VREAD);
  assign bus_wdata_o = (state_q == ST_RDRST) ? '0 : lane_cmd;
endmodule

// File: rtl/zes_checker.sv
module zes_checker #(
  parameter int unsigned AW         = 8,
  parameter int unsigned LANES      = 2,
  parameter int unsigned MAX_PULSES = 25,
  localparam int unsigned DW        = 8 * LANES,
  localparam int unsigned PW        = $clog2(MAX_PULSES + 2)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          prg_req_o,
  input logic          bus_we_o,
  input logic          bus_re_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o
);
  logic          prev_we, vvalid, any_erase, any_vfy, is_pulse, accept;
  logic [DW-1:0] prev_d;
  logic [AW-1:0] vlast;
  logic [PW-1:0] pcnt;

  always_comb begin
    any_erase = 1'b0;
    any_vfy   = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (bus_wdata_o[8*l +: 8] == 8'h20) any_erase = 1'b1;
      if (bus_wdata_o[8*l +: 8] == 8'hA0) any_vfy   = 1'b1;
    end
  end

  assign is_pulse = bus_we_o && prev_we && any_erase && (prev_d == bus_wdata_o);
  assign accept   = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_we <= 1'b0;
      prev_d  <= '0;
      pcnt    <= '0;
      vlast   <= '0;
      vvalid  <= 1'b0;
    end else begin
      prev_we <= bus_we_o;
      prev_d  <= bus_wdata_o;
      if (accept) pcnt <= '0;
      else if (is_pulse && pcnt != PW'(MAX_PULSES + 1)) pcnt <= pcnt + PW'(1);
      if (accept) vvalid <= 1'b0;
      else if (bus_we_o && any_vfy) begin
        vlast  <= bus_addr_o;
        vvalid <= 1'b1;
      end
    end
  end

  AST_NO_RW_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o)); // R4
  AST_PRG_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_req_o |-> (!bus_we_o && !bus_re_o)); // R2
  AST_VFY_NO_BACKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && any_vfy && vvalid) |-> (bus_addr_o >= vlast)); // R6
  AST_PULSE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt <= PW'(MAX_PULSES)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o)); // R9
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !busy_o && !start_i) |=> done_o); // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !done_o || !busy_o); // R10
endmodule

bind zone_erase_seq zes_checker #(
  .AW(AW), .LANES(LANES), .MAX_PULSES(MAX_PULSES)
) u_zes_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .prg_req_o   (prg_req_o),
  .bus_we_o    (bus_we_o),
  .bus_re_o    (bus_re_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o)
);

// File: tb/zone_erase_seq_tb_top.sv
`timescale 1ns/1ps
module zone_erase_seq_tb_top;
  localparam int AW = 6, LANES = 2, DW = 16;
  localparam int ERASE_CYC = 4, SETTLE_CYC = 2, MAX_PULSES = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, prg_done_i = 1'b0, prg_fail_i = 1'b0;
  logic [AW-1:0] base_i = '0, size_i = '0;
  logic [DW-1:0] bus_rdata_i = '0;
  logic prg_req_o, bus_we_o, bus_re_o, busy_o, done_o, err_o;
  logic [AW-1:0] prg_addr_o, bus_addr_o;
  logic [DW-1:0] bus_wdata_o;

  always #2 clk = ~clk;

  zone_erase_seq #(.AW(AW), .LANES(LANES), .ERASE_CYC(ERASE_CYC),
                   .SETTLE_CYC(SETTLE_CYC), .MAX_PULSES(MAX_PULSES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .base_i(base_i), .size_i(size_i),
    .prg_req_o(prg_req_o), .prg_addr_o(prg_addr_o), .prg_done_i(prg_done_i),
    .prg_fail_i(prg_fail_i), .bus_we_o(bus_we_o), .bus_re_o(bus_re_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  int n_chk = 0, n_fail = 0;
  int pat = 0, m_base = 0, m_size = 0;
  bit fail_mode = 0, running = 0;
  bit prog [64];
  int lp [LANES];
  bit prev20 [LANES];
  int prg_cnt, pdly, pulses, vcnt, cyc, t_erase, t_vfy, vlast;
  bit prg_bad, order_bad, mono_bad, time_bad, erase_pend, vseen;
  logic [DW-1:0] last_wr;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int need_f(input int a, input int l);
    case (pat)
      0: return 1;
      1: return ((a * 2 + l) % 3) + 1;
      2: return (((a + 2 * l) % 4) == 3) ? 3 : 1;
      default: return (a == 1 && l == 0) ? 20 : 1;
    endcase
  endfunction

  // pulses an erase loop needs with per-lane masking and resume
  task automatic expect_run(input int size, output int p, output int c0, output int c1);
    int c [LANES];
    for (int l = 0; l < LANES; l++) c[l] = 1;
    p = 1;
    for (int a = 0; a < size; a++) begin
      while (need_f(a, 0) > c[0] || need_f(a, 1) > c[1]) begin
        p++;
        for (int l = 0; l < LANES; l++) if (need_f(a, l) > c[l]) c[l]++;
      end
    end
    c0 = c[0];
    c1 = c[1];
  endtask

  // array and program controller model, driven away from the active edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      cyc++;
      if (prg_req_o) begin
        if (pdly == 2) begin
          prg_done_i = 1'b1;
          prg_fail_i = fail_mode && (prg_cnt == 1);
          if (int'(prg_addr_o) != m_base + prg_cnt) prg_bad = 1;
          prog[prg_addr_o] = 1;
          prg_cnt++;
          pdly = 0;
        end else begin
          prg_done_i = 1'b0;
          prg_fail_i = 1'b0;
          pdly++;
        end
      end else begin
        prg_done_i = 1'b0;
        prg_fail_i = 1'b0;
        pdly = 0;
      end
      if (bus_we_o) begin
        bit pa, va;
        pa = 0;
        va = 0;
        last_wr = bus_wdata_o;
        for (int l = 0; l < LANES; l++) begin
          if (bus_wdata_o[8*l +: 8] == 8'h20) begin
            if (prev20[l]) begin lp[l]++; pa = 1; prev20[l] = 0; end
            else prev20[l] = 1;
          end else prev20[l] = 0;
          if (bus_wdata_o[8*l +: 8] == 8'hA0) va = 1;
        end
        if (pa) begin
          pulses++;
          t_erase = cyc;
          erase_pend = 1;
          if (prg_cnt != m_size) order_bad = 1;
        end
        if (va) begin
          vcnt++;
          if (vseen && int'(bus_addr_o) < vlast) mono_bad = 1;
          vlast = int'(bus_addr_o);
          vseen = 1;
          if (erase_pend && cyc - t_erase != ERASE_CYC + 1) time_bad = 1;
          erase_pend = 0;
          t_vfy = cyc;
        end
      end else begin
        for (int l = 0; l < LANES; l++) prev20[l] = 0;
      end
      if (bus_re_o && cyc - t_vfy != SETTLE_CYC + 1) time_bad = 1;
      for (int l = 0; l < LANES; l++) begin
        int a;
        a = int'(bus_addr_o) - m_base;
        if (need_f(a, l) <= lp[l]) bus_rdata_i[8*l +: 8] = 8'hFF;
        else bus_rdata_i[8*l +: 8] = prog[bus_addr_o] ? 8'h00 : 8'h5A;
      end
    end
  end

  task automatic run_zone(input int base, input int size, input int p_sel,
                          input bit fmode, input bit poke);
    int exp_p, c0, c1, t;
    bit ok_end;
    @(negedge clk);
    pat = p_sel; m_base = base; m_size = size; fail_mode = fmode;
    for (int i = 0; i < 64; i++) prog[i] = 0;
    for (int l = 0; l < LANES; l++) begin lp[l] = 0; prev20[l] = 0; end
    prg_cnt = 0; pdly = 0; pulses = 0; vcnt = 0; cyc = 0; t_erase = 0; t_vfy = 0;
    vlast = 0; prg_bad = 0; order_bad = 0; mono_bad = 0; time_bad = 0;
    erase_pend = 0; vseen = 0; last_wr = '1;
    running = 1;
    base_i = AW'(base); size_i = AW'(size); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t = 0;
    ok_end = 0;
    while (t < 20000) begin
      @(negedge clk);
      t++;
      if (poke && t == 20) begin base_i = '0; size_i = AW'(1); start_i = 1'b1; end
      else start_i = 1'b0;
      if (!busy_o && done_o) begin ok_end = 1; break; end
    end
    running = 0;
    check(ok_end, "R9 run did not finish (watchdog)", t, 20000);
    if (!ok_end) return;
    expect_run(size, exp_p, c0, c1);
    check(last_wr == '0, "R9 final read-mode write", int'(last_wr), 0);
    if (fmode) begin
      check(err_o == 1'b1, "R3 err after program failure", err_o, 1);
      check(pulses == 0, "R3 no erase pulse after program failure", pulses, 0);
      return;
    end
    check(!prg_bad && prg_cnt == size, "R2 pre-program count/order", prg_cnt, size);
    check(!order_bad, "R2 erase pulse before pre-program end", order_bad, 0);
    check(!time_bad, "R4 erase/settle wait timing", time_bad, 0);
    if (exp_p > MAX_PULSES) begin
      check(err_o == 1'b1, "R8 err on pulse budget exhausted", err_o, 1);
      check(pulses == MAX_PULSES, "R8 pulses issued under budget limit", pulses, MAX_PULSES);
    end else begin
      check(err_o == 1'b0, "R9 no err on full erase", err_o, 0);
      check(pulses == exp_p, "R5 total erase pulses", pulses, exp_p);
      check(lp[0] == c0, "R7 lane0 pulses with masking", lp[0], c0);
      check(lp[1] == c1, "R7 lane1 pulses with masking", lp[1], c1);
      check(!mono_bad && vcnt == size + exp_p - 1, "R6 verify resume count",
            vcnt, size + exp_p - 1);
      if (poke) check(prog[0] == 0 || base == 0, "R10 start during run ignored", prog[0], 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !err_o, "R1 reset status low",
          {busy_o, done_o, err_o}, 0);
    check(!prg_req_o && !bus_we_o && !bus_re_o, "R1 reset strobes low",
          {prg_req_o, bus_we_o, bus_re_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int p = 0; p < 3; p++)
      for (int s = 1; s <= 6; s++)
        run_zone(p * 9 + s, s, p, 1'b0, 1'b0);
    run_zone(20, 4, 1, 1'b0, 1'b1);    // R10 poke start mid-run
    check(done_o == 1'b1, "R9 done held while idle", done_o, 1);
    run_zone(5, 3, 3, 1'b0, 1'b0);     // R8 budget exhaustion
    check(err_o == 1'b1 && done_o == 1'b1, "R9 err and done held", {err_o, done_o}, 3);
    run_zone(8, 3, 0, 1'b1, 1'b0);     // R3 program failure
    run_zone(30, 2, 2, 1'b0, 1'b0);    // err cleared by new start
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule